// File: doc/BRIEF.md
# Programmable-Edge SPI Master Engine

This block drives one serial transfer at a time to one of up to four peripheral targets on a shared serial clock and data-out line. A simple settings port (a write strobe, an 8-bit address and a 32-bit word) holds the clock divider and a control word. The control word selects the target, the number of bits and, independently, the serial clock edge on which outgoing data changes and the edge on which incoming data is sampled. A write to the data address starts the transfer. The outgoing payload is left-justified in that 32-bit word.

While a transfer runs, the ready flag is low and the selected active-low chip select is held asserted. When the transfer finishes, the chip select is released and a one-cycle readback strobe comes with the received bits. Those bits stay on the readback port until the next transfer completes.

The settings port has no back-pressure. The ready flag is its only flow signal: a start write is accepted only while ready is high and is dropped otherwise. The readback strobe is a single-cycle pulse that cannot be stalled, so a consumer must take the word in the strobe cycle or read the held value later.

Top module: `spi_master_engine`

## Requirements
- R1: The serial clock period is (divider + 1) system clocks and the high phase lasts floor((divider + 1) / 2) clocks. A divider of 0 behaves as 1.
- R2: A write to settings address 0 loads the divider from data[15:0]. Address 1 loads the control word. Address 2 starts a transfer with the written payload. Writes to any other address change nothing.
- R3: The control field data[13:8] gives the number of bits, from 1 to 32. A value of 0 or above 32 means 32. A transfer produces exactly that many serial clock pulses.
- R4: The first bit sent is payload bit 31, and the following bits go out in descending order. Payload bits below position 32 - length are never sent.
- R5: Control bit 16 selects the edge on which outgoing data changes. When it is 0, the data changes on falling edges and the first bit is on the line before the first rising edge. When it is 1, each bit is launched on a rising edge.
- R6: Control bit 17 selects the edge on which incoming data is sampled: 0 samples on falling edges and 1 samples on rising edges.
- R7: Control field data[1:0] selects the target. For the whole transfer, exactly that chip-select line is low, and at no time is more than one line low.
- R8: Ready is high only when the engine is idle. It goes low in the cycle after an accepted start. A start write while busy is ignored. Settings written while busy do not affect the running transfer but apply to the next one.
- R9: Received bits shift into the readback word from bit 0 upward, so the last bit received is in bit 0 and the unused upper bits are zero. The readback strobe pulses for one cycle, in the same cycle that the chip select is released and ready rises. The readback word then stays unchanged until the next strobe.
- R10: While idle, the serial clock and the data-out line are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| set_stb | input | 1 | Settings write strobe |
| set_addr | input | 8 | Settings address |
| set_data | input | 32 | Settings write data |
| spi_miso | input | 1 | Serial data from the target |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the target |
| spi_cs_n | output | NUM_TGT | Active-low target selects |
| ready | output | 1 | Engine idle and able to start |
| rd_data | output | 32 | Bits received in the last completed transfer |
| rd_stb | output | 1 | One-cycle pulse when a transfer completes |

## Verification
The bench runs all four combinations of launch edge and sample edge against a peripheral model that moves to its next bit only after the edge on which it expects to be sampled. A design that samples on the wrong edge therefore reads a shifted or duplicated bit. Odd dividers and divider 0 expose an off-by-one in the high or low phase as a wrong measured period. Lengths of 1, 32 and the out-of-range 0 expose a miscounted bit counter as extra or missing clock pulses. A start and a control write injected mid-transfer, plus writes to unused addresses, catch a design that restarts, changes target partway through, or lets ignored writes leak into the next transfer's settings.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam int WORD_W   = 32;
  localparam int LEN_W    = 6;
  localparam int TGT_W    = 2;

  localparam logic [7:0] ADDR_DIV  = 8'd0;
  localparam logic [7:0] ADDR_CTRL = 8'd1;
  localparam logic [7:0] ADDR_DATA = 8'd2;

  typedef struct packed {
    logic             sample_rise;
    logic             launch_rise;
    logic [LEN_W-1:0] nbits;
    logic [TGT_W-1:0] tgt;
  } spim_cfg_t;

  function automatic spim_cfg_t unpack_ctrl(input logic [WORD_W-1:0] w);
    spim_cfg_t c;
    c.tgt         = w[1:0];
    c.nbits       = w[13:8];
    c.launch_rise = w[16];
    c.sample_rise = w[17];
    return c;
  endfunction

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] n);
    if (n == '0 || n > LEN_W'(WORD_W)) return LEN_W'(WORD_W);
    return n;
  endfunction

endpackage

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set_stb,
  input  logic [7:0]           set_addr,
  input  logic [WORD_W-1:0]    set_data,
  input  logic                 idle,
  output logic [DIV_W-1:0]     div_q,
  output spim_cfg_t            cfg_q,
  output logic                 start
);

  wire unused_set_bits = ^set_data;

  assign start = set_stb && (set_addr == ADDR_DATA) && idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= DIV_W'(1);
      cfg_q <= '0;
    end else if (set_stb) begin
      if (set_addr == ADDR_DIV)  div_q <= set_data[DIV_W-1:0];
      if (set_addr == ADDR_CTRL) cfg_q <= unpack_ctrl(set_data);
    end
  end

endmodule

// File: rtl/spim_edge_gen.sv
module spim_edge_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             rise_ev,
  output logic             fall_ev,
  output logic             sclk
);

  localparam int CW = DIV_W + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] period;
  logic [CW-1:0] hi_len;
  logic [CW-1:0] lo_len;

  assign period  = CW'(div) + CW'(1);
  assign hi_len  = period >> 1;
  assign lo_len  = period - hi_len;
  assign rise_ev = run && (cnt == lo_len - CW'(1));
  assign fall_ev = run && (cnt == CW'(div));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else begin
      cnt <= fall_ev ? '0 : cnt + CW'(1);
      if (rise_ev)      sclk <= 1'b1;
      else if (fall_ev) sclk <= 1'b0;
    end
  end

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rise_ev && fall_ev)); // R1
  AST_FALL_FROM_HIGH: assert property (@(posedge clk) disable iff (rst)
    fall_ev |-> sclk); // R1

endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              active,
  input  logic [WORD_W-1:0] payload,
  input  spim_cfg_t         cfg,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rx,
  output logic              last_fall
);

  logic [WORD_W-1:0] txsr;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  bitcnt;
  logic              launch_rise_q;
  logic              sample_rise_q;
  logic              launch_ev;
  logic              sample_ev;

  assign launch_ev = launch_rise_q ? rise_ev : fall_ev;
  assign sample_ev = sample_rise_q ? rise_ev : fall_ev;
  assign last_fall = fall_ev && (bitcnt == len_q - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      txsr          <= '0;
      rx            <= '0;
      len_q         <= LEN_W'(WORD_W);
      bitcnt        <= '0;
      mosi          <= 1'b0;
      launch_rise_q <= 1'b0;
      sample_rise_q <= 1'b0;
    end else if (load) begin
      len_q         <= clamp_len(cfg.nbits);
      launch_rise_q <= cfg.launch_rise;
      sample_rise_q <= cfg.sample_rise;
      rx            <= '0;
      bitcnt        <= '0;
      if (cfg.launch_rise) begin
        txsr <= payload;
        mosi <= 1'b0;
      end else begin
        txsr <= payload << 1;
        mosi <= payload[WORD_W-1];
      end
    end else begin
      if (launch_ev) begin
        mosi <= txsr[WORD_W-1];
        txsr <= txsr << 1;
      end
      if (sample_ev) rx <= {rx[WORD_W-2:0], miso};
      if (fall_ev)   bitcnt <= bitcnt + LEN_W'(1);
    end
  end

  AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    active |-> (bitcnt < len_q)); // R3

endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
  import spim_pkg::*;
#(
  parameter int NUM_TGT = 4,
  parameter int DIV_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_stb,
  input  logic [7:0]         set_addr,
  input  logic [31:0]        set_data,
  input  logic               spi_miso,
  output logic               spi_sclk,
  output logic               spi_mosi,
  output logic [NUM_TGT-1:0] spi_cs_n,
  output logic               ready,
  output logic [31:0]        rd_data,
  output logic               rd_stb
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TAIL} state_t;

  state_t            state;
  logic [DIV_W-1:0]  div_q;
  logic [DIV_W-1:0]  div_run;
  spim_cfg_t         cfg_q;
  logic              start;
  logic              run;
  logic              rise_ev;
  logic              fall_ev;
  logic              sh_mosi;
  logic              sh_last;
  logic [WORD_W-1:0] sh_rx;
  logic [NUM_TGT-1:0] sel_n;

  assign ready    = (state == ST_IDLE);
  assign run      = (state == ST_RUN);
  assign spi_mosi = !ready && sh_mosi;

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_sel
    assign sel_n[g] = !(int'(cfg_q.tgt) == g);
  end

  spim_regs #(.DIV_W(DIV_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .set_stb  (set_stb),
    .set_addr (set_addr),
    .set_data (set_data),
    .idle     (ready),
    .div_q    (div_q),
    .cfg_q    (cfg_q),
    .start    (start)
  );

  spim_edge_gen #(.DIV_W(DIV_W)) u_edge (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .div     (div_run),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev),
    .sclk    (spi_sclk)
  );

  spim_shift u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (start),
    .active    (run),
    .payload   (set_data),
    .cfg       (cfg_q),
    .rise_ev   (rise_ev),
    .fall_ev   (fall_ev),
    .miso      (spi_miso),
    .mosi      (sh_mosi),
    .rx        (sh_rx),
    .last_fall (sh_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      div_run  <= DIV_W'(1);
      spi_cs_n <= '1;
      rd_stb   <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_stb <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state    <= ST_RUN;
          div_run  <= (div_q == '0) ? DIV_W'(1) : div_q;
          spi_cs_n <= sel_n;
        end
        ST_RUN: if (sh_last) state <= ST_TAIL;
        ST_TAIL: begin
          state    <= ST_IDLE;
          spi_cs_n <= '1;
          rd_stb   <= 1'b1;
          rd_data  <= sh_rx;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $countones(~spi_cs_n) <= 1); // R7
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
    ready |-> (!spi_sclk && !spi_mosi)); // R10
  AST_STB_AT_END: assert property (@(posedge clk) disable iff (rst)
    rd_stb |-> (ready && (&spi_cs_n) && $past(!ready))); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |-> $stable(rd_data)); // R9
  AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
    (ready && start) |=> !ready); // R8

endmodule

// File: tb/tb_spi_master_engine.sv
module tb_spi_master_engine;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        set_stb = 1'b0;
  logic [7:0]  set_addr = '0;
  logic [31:0] set_data = '0;
  logic        spi_miso;
  logic        spi_sclk, spi_mosi, ready, rd_stb;
  logic [3:0]  spi_cs_n;
  logic [31:0] rd_data;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  spi_master_engine dut (
    .clk(clk), .rst(rst), .set_stb(set_stb), .set_addr(set_addr),
    .set_data(set_data), .spi_miso(spi_miso), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .ready(ready),
    .rd_data(rd_data), .rd_stb(rd_stb)
  );

  typedef struct {
    logic [31:0] rx;
    logic [31:0] tx;
    int          len;
    int          per;
    int          hi;
    logic [3:0]  csn;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] sl_pat = '0;
  logic        m_launch_rise = 1'b0;
  logic        m_sample_rise = 1'b0;
  int          n_push = 0;
  int          n_stb  = 0;
  logic [31:0] last_rx = '0;
  logic [15:0] cur_div = 16'd1;
  logic [31:0] cur_ctrl = '0;

  assign spi_miso = sl_pat[31];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor
  logic        prev_sclk = 1'b0;
  logic [31:0] got_tx = '0;
  int          nrise = 0, since_rise = 0, per_meas = 0, hi_first = 0;
  bit          cs_bad = 0;

  always @(negedge clk) begin
    if (!rst) begin
      automatic bit r = !prev_sclk && spi_sclk;
      automatic bit f = prev_sclk && !spi_sclk;
      since_rise++;
      if (r) begin
        nrise++;
        if (nrise == 2) per_meas = since_rise;
        since_rise = 0;
        if (sb_q.size() == 0 || spi_cs_n !== sb_q[0].csn) cs_bad = 1;
      end
      if (spi_sclk && nrise == 1) hi_first++;
      if ((!m_launch_rise && r) || (m_launch_rise && f)) got_tx = {got_tx[30:0], spi_mosi};
      if ((m_sample_rise && r) || (!m_sample_rise && f)) sl_pat = sl_pat << 1;
      if (rd_stb) begin
        n_stb++;
        if (sb_q.size() == 0) begin
          chk(0, "R9 unexpected strobe", 32'd1, 32'd0);
        end else begin
          automatic exp_t e = sb_q.pop_front();
          chk(rd_data === e.rx, "R6/R9 readback", rd_data, e.rx);
          chk(got_tx === e.tx, "R4/R5 mosi bits", got_tx, e.tx);
          chk(nrise == e.len, "R3 pulse count", nrise, e.len);
          chk(hi_first == e.hi, "R1 high phase", hi_first, e.hi);
          if (e.len >= 2) chk(per_meas == e.per, "R1 period", per_meas, e.per);
          chk(!cs_bad, "R7 target select", cs_bad, 0);
          chk(ready === 1'b1 && spi_cs_n === 4'hF, "R9 strobe at release", {ready, spi_cs_n}, 5'h1F);
          last_rx = e.rx;
        end
        got_tx = '0; nrise = 0; since_rise = 0; per_meas = 0; hi_first = 0; cs_bad = 0;
      end
      prev_sclk = spi_sclk;
    end
  end

  task automatic set_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    set_stb = 1'b1; set_addr = a; set_data = d;
    @(negedge clk);
    set_stb = 1'b0;
  endtask

  function automatic logic [31:0] mk_ctrl(input logic [1:0] tgt, input logic [5:0] len,
                                          input logic lr, input logic sr);
    return {14'b0, sr, lr, 2'b0, len, 6'b0, tgt};
  endfunction

  task automatic xfer(input bit wr_cfg, input logic [15:0] div, input logic [31:0] ctrl,
                      input logic [31:0] tx, input logic [31:0] pat, input bit poke,
                      input logic [31:0] poke_ctrl);
    exp_t e;
    int d, len;
    if (wr_cfg) begin
      set_wr(8'd0, {16'hBEEF, div});
      set_wr(8'd1, ctrl);
      cur_div = div; cur_ctrl = ctrl;
    end
    d   = (cur_div == 0) ? 1 : int'(cur_div);
    len = int'(cur_ctrl[13:8]);
    if (len == 0 || len > 32) len = 32;
    e.len = len;
    e.per = d + 1;
    e.hi  = (d + 1) / 2;
    e.tx  = tx >> (32 - len);
    e.rx  = pat >> (32 - len);
    e.csn = ~(4'b0001 << cur_ctrl[1:0]);
    m_launch_rise = cur_ctrl[16];
    m_sample_rise = cur_ctrl[17];
    sl_pat = pat;
    sb_q.push_back(e);
    n_push++;
    set_wr(8'd2, tx);
    chk(ready === 1'b0, "R8 ready low after start", ready, 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      set_wr(8'd2, ~tx);
      set_wr(8'd1, poke_ctrl);
      set_wr(8'd0, 32'd7);
      cur_ctrl = poke_ctrl; cur_div = 16'd7;
    end
    while (n_stb < n_push) @(negedge clk);
    @(negedge clk);
    chk(ready === 1'b1, "R8 ready high when idle", ready, 1);
    chk(spi_sclk === 1'b0 && spi_mosi === 1'b0, "R10 idle lines", {spi_sclk, spi_mosi}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ready === 1'b1, "R8 reset ready", ready, 1);
    chk(spi_cs_n === 4'hF, "R7 reset selects", spi_cs_n, 4'hF);
    chk(spi_sclk === 1'b0 && spi_mosi === 1'b0, "R10 reset lines", {spi_sclk, spi_mosi}, 0);
    chk(rd_stb === 1'b0 && rd_data === 32'h0, "R9 reset readback", rd_data, 0);

    // R5 falling launch, R6 rising sample, R1 even period
    xfer(1, 16'd3, mk_ctrl(2'd0, 6'd8, 1'b0, 1'b1), 32'hA500_0000, 32'h3C00_0000, 0, 0);
    // R5 rising launch, R6 falling sample, R1 odd period
    xfer(1, 16'd4, mk_ctrl(2'd2, 6'd12, 1'b1, 1'b0), 32'h9F30_0000, 32'h5A70_0000, 0, 0);
    // R1 divider 0 acts as 1, R3 full 32 bits, both falling
    xfer(1, 16'd0, mk_ctrl(2'd3, 6'd32, 1'b0, 1'b0), 32'hDEAD_BEEF, 32'h1234_5678, 0, 0);
    // R3 single bit, both rising
    xfer(1, 16'd2, mk_ctrl(2'd1, 6'd1, 1'b1, 1'b1), 32'h8000_0000, 32'h8000_0000, 0, 0);
    // R3 length 0 means 32
    xfer(1, 16'd1, mk_ctrl(2'd0, 6'd0, 1'b0, 1'b1), 32'h0F0F_A5C3, 32'hC001_D00D, 0, 0);
    // R8 writes while busy; R4 low payload bits ignored
    xfer(1, 16'd2, mk_ctrl(2'd1, 6'd16, 1'b0, 1'b1), 32'hC3A5_00FF, 32'hF00D_FFFF, 1,
         mk_ctrl(2'd3, 6'd5, 1'b1, 1'b0));
    chk(n_stb == 6, "R8 busy start ignored", n_stb, 6);
    // R8 settings from busy writes apply to next transfer
    xfer(0, 16'd0, 32'h0, 32'hB87F_FFFF, 32'h5000_0000, 0, 0);
    // R2 other addresses ignored
    set_wr(8'd3, 32'hFFFF_FFFF);
    set_wr(8'd5, 32'h0000_0000);
    set_wr(8'd255, 32'h0003_2000);
    chk(n_stb == 7 && ready === 1'b1, "R2 stray address no start", n_stb, 7);
    xfer(0, 16'd0, 32'h0, 32'h6800_0000, 32'hA000_0000, 0, 0);

    repeat (20) @(negedge clk);
    chk(rd_data === last_rx, "R9 readback held", rd_data, last_rx);
    chk(n_stb == n_push && sb_q.size() == 0, "R9 one strobe per transfer", n_stb, n_push);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule